// File: doc/BRIEF.md
# Pipeline Interlock and Operand Bypass Controller

This block is the hazard logic of a five-stage in-order integer pipeline whose stages run fetch, decode, execute, memory, writeback. The pipeline runs loads, stores and register-to-register add and subtract. The controller is purely combinational. Each cycle it compares the source registers of the instruction in decode with the destination registers of the instructions in execute and memory. From this it decides whether fetch and decode must hold and whether execute must take an empty slot. It also compares the execute-stage operand registers and the memory-stage store-data register with the destinations further down the pipe, and steers the bypass multiplexers.

A static mode input selects between two pipelines. In the bypassing pipeline, results are taken from the memory or writeback stage into execute. In the pipeline without bypassing, a consumer waits in decode until its producer reaches writeback. The register file writes in the first half of a cycle and reads in the second, so a consumer released in that cycle reads the fresh value. Store data gets special treatment. It is consumed only in the memory stage, so a store directly after a load never waits for its data operand. The value is instead bypassed from writeback into the memory stage.

Top module: `hazard_ctrl`

## Requirements
- R1: `stall_o` and `ex_bubble_o` are always equal. While they are high, the program counter and the decode register hold, and the execute stage takes an empty slot with every write enable cleared.
- R2: With bypassing on, a decode instruction whose execute-time operand matches the destination of a load in execute stalls for exactly one cycle. The execute-time operand is the first source, or the second source when it is not store data.
- R3: With bypassing on, an ALU result needed by the following instruction causes no stall. Execute operand selects use the code 0 for the register file, 1 for the memory-stage result and 2 for the writeback-stage result.
- R4: When both the memory and writeback stages write an operand's register, the select takes the memory stage, which is the younger producer. A load in the memory stage is never selected.
- R5: With bypassing off, a consumer stalls while its producer is in execute or memory and proceeds when the producer is in writeback. That is two stall cycles for adjacent instructions. All selects stay at 0 and `mem_sd_fwd_o` stays low.
- R6: With bypassing on, a store whose data register (second source) is written by the load directly ahead does not stall. In the memory stage, `mem_sd_fwd_o` then selects the writeback value. A dependence through the base register (first source) follows R2.
- R7: Register 0 never causes a stall and is never bypassed.
- R8: An instruction with its write enable low never causes a stall or a bypass, even when its destination field matches.
- R9: The sequence load, dependent load, add of the second load's result, subtract of the add's result completes its last writeback in cycle 10 with bypassing and cycle 14 without. Cycle 1 is the fetch of the first instruction.
- R10: That four-instruction group repeated 100 times completes in cycle 604 with bypassing and cycle 1004 without, with no stall between groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, used for the property checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fwd_en_i | input | 1 | Static mode: 1 bypassing pipeline, 0 no bypassing |
| id_rs1_i | input | 5 | Decode first source (base or ALU operand A) |
| id_rs2_i | input | 5 | Decode second source (ALU operand B or store data) |
| id_use_rs1_i | input | 1 | Decode instruction reads first source |
| id_use_rs2_i | input | 1 | Decode instruction reads second source |
| id_store_i | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rd_i | input | 5 | Execute destination |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_rs1_i | input | 5 | Execute first source |
| ex_rs2_i | input | 5 | Execute second source |
| mem_rd_i | input | 5 | Memory-stage destination |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| mem_store_i | input | 1 | Memory-stage instruction is a store |
| mem_rs2_i | input | 5 | Memory-stage store-data register |
| wb_rd_i | input | 5 | Writeback destination |
| wb_wen_i | input | 1 | Writeback instruction writes a register |
| stall_o | output | 1 | Hold program counter and decode register |
| ex_bubble_o | output | 1 | Insert empty slot into execute |
| fwd_a_o | output | 2 | Execute operand A select |
| fwd_b_o | output | 2 | Execute operand B select |
| mem_sd_fwd_o | output | 1 | Store data in memory stage taken from writeback |

## Verification
The embedded properties check every cycle that a stall is always followed by an empty execute slot. They check that a load-use stall in bypassing mode lasts one cycle, and that stalls without bypassing never run longer than two. They also check that register 0, non-writing instructions and loads in the memory stage never drive a stall or a bypass, that selects stay idle without bypassing, and that store data after a load never stalls. The exact cycle counts of the load/add/subtract sequences, and the data each bypass choice delivers, are shown only by the bench. The bench runs a cycle-level pipeline model on the controller's outputs and compares store data and final register contents with an in-order reference.

// File: rtl/hazard_pkg.sv
`timescale 1ns/1ps
package hazard_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_RF  = 2'd0,
    SEL_MEM = 2'd1,
    SEL_WB  = 2'd2
  } opnd_sel_e;
endpackage

// File: rtl/hazard_stall_unit.sv
`timescale 1ns/1ps
module hazard_stall_unit #(
  parameter int unsigned REG_AW = 5,
  parameter int unsigned N_SRC  = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fwd_en_i,
  input  logic [N_SRC-1:0][REG_AW-1:0] src_i,
  input  logic [N_SRC-1:0]             use_i,
  input  logic [N_SRC-1:0]             late_i,
  input  logic [REG_AW-1:0]            ex_rd_i,
  input  logic                         ex_wen_i,
  input  logic                         ex_load_i,
  input  logic [REG_AW-1:0]            mem_rd_i,
  input  logic                         mem_wen_i,
  output logic                         stall_o
);
  logic [N_SRC-1:0] src_hit;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic live, ex_hit, mem_hit;
    assign live    = use_i[k] && (src_i[k] != '0);
    assign ex_hit  = ex_wen_i && (ex_rd_i == src_i[k]);
    assign mem_hit = mem_wen_i && (mem_rd_i == src_i[k]);
    // late operands (store data) are consumed in memory stage: no load-use wait
    assign src_hit[k] = live && (fwd_en_i ? (ex_hit && ex_load_i && !late_i[k])
                                          : (ex_hit || mem_hit));
  end

  assign stall_o = |src_hit;

  AST_STALL_HAS_PRODUCER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_wen_i || mem_wen_i)); // R8
  AST_FWD_ONLY_LOADS_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_i && stall_o) |-> (ex_load_i && ex_wen_i)); // R3
endmodule

// File: rtl/hazard_fwd_sel.sv
`timescale 1ns/1ps
module hazard_fwd_sel
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output logic [SEL_W-1:0]  sel_o
);
  opnd_sel_e sel;

  always_comb begin
    sel = SEL_RF;
    if (fwd_en_i && (src_i != '0)) begin
      // youngest producer first; a load result is not ready in memory stage
      if (mem_wen_i && !mem_load_i && (mem_rd_i == src_i)) sel = SEL_MEM;
      else if (wb_wen_i && (wb_rd_i == src_i))              sel = SEL_WB;
    end
  end

  assign sel_o = sel;

  AST_NOFWD_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_en_i |-> (sel_o == SEL_RF)); // R5
  AST_NO_MEM_LOAD_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_load_i |-> (sel_o != SEL_MEM)); // R4
  AST_ZERO_REG_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |-> (sel_o == SEL_RF)); // R7
  AST_SEL_NEEDS_WRITER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != SEL_RF) |-> (mem_wen_i || wb_wen_i)); // R8
endmodule

// File: rtl/hazard_ctrl.sv
`timescale 1ns/1ps
module hazard_ctrl
  import hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwd_en_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              id_store_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_wen_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_wen_i,
  input  logic              mem_load_i,
  input  logic              mem_store_i,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_wen_i,
  output logic              stall_o,
  output logic              ex_bubble_o,
  output logic [SEL_W-1:0]  fwd_a_o,
  output logic [SEL_W-1:0]  fwd_b_o,
  output logic              mem_sd_fwd_o
);
  localparam int unsigned N_SRC = 2;

  logic [N_SRC-1:0][REG_AW-1:0] id_src, ex_src;
  logic [N_SRC-1:0]             id_use, id_late;
  logic [N_SRC-1:0][SEL_W-1:0]  ex_sel;

  assign id_src  = {id_rs2_i, id_rs1_i};
  assign id_use  = {id_use_rs2_i, id_use_rs1_i};
  assign id_late = {id_store_i, 1'b0};
  assign ex_src  = {ex_rs2_i, ex_rs1_i};

  hazard_stall_unit #(.REG_AW(REG_AW), .N_SRC(N_SRC)) u_stall (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fwd_en_i  (fwd_en_i),
    .src_i     (id_src),
    .use_i     (id_use),
    .late_i    (id_late),
    .ex_rd_i   (ex_rd_i),
    .ex_wen_i  (ex_wen_i),
    .ex_load_i (ex_load_i),
    .mem_rd_i  (mem_rd_i),
    .mem_wen_i (mem_wen_i),
    .stall_o   (stall_o)
  );

  for (genvar k = 0; k < N_SRC; k++) begin : g_opnd
    hazard_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fwd_en_i   (fwd_en_i),
      .src_i      (ex_src[k]),
      .mem_rd_i   (mem_rd_i),
      .mem_wen_i  (mem_wen_i),
      .mem_load_i (mem_load_i),
      .wb_rd_i    (wb_rd_i),
      .wb_wen_i   (wb_wen_i),
      .sel_o      (ex_sel[k])
    );
  end

  assign fwd_a_o     = ex_sel[0];
  assign fwd_b_o     = ex_sel[1];
  assign ex_bubble_o = stall_o;

  // store data late bypass: writeback holds the instruction directly ahead
  assign mem_sd_fwd_o = fwd_en_i && mem_store_i && wb_wen_i &&
                        (wb_rd_i != '0) && (wb_rd_i == mem_rs2_i);

  AST_BUBBLE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (!ex_wen_i && !ex_load_i)); // R1
  AST_LOAD_USE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_i && stall_o) |=> !stall_o); // R2
  AST_NOFWD_TWO_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwd_en_i && stall_o && $past(stall_o)) |=> !stall_o); // R5
  AST_STORE_DATA_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_en_i && id_store_i && id_use_rs2_i && ex_load_i && ex_wen_i &&
     (ex_rd_i == id_rs2_i) && !(id_use_rs1_i && (id_rs1_i == ex_rd_i)) &&
     !(ex_wen_i && !ex_load_i)) |-> !stall_o); // R6
  AST_SD_NOFWD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fwd_en_i) |-> !mem_sd_fwd_o); // R5
endmodule

// File: tb/hazard_ctrl_tb.sv
`timescale 1ns/1ps
module hazard_ctrl_tb;
  localparam int OP_NOP = 0, OP_LW = 1, OP_SW = 2, OP_ADD = 3, OP_SUB = 4;
  localparam int PMAX = 512;

  logic clk = 1'b0;
  logic rst_n;
  logic fwd_en;
  logic [4:0] id_rs1, id_rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd;
  logic id_use1, id_use2, id_store, ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen;
  logic stall, bubble, sdf;
  logic [1:0] fa, fb;

  int n_vec = 0, n_fail = 0, wd_cnt = 0;

  int          p_op [PMAX];
  logic [4:0]  p_rd [PMAX], p_rs1 [PMAX], p_rs2 [PMAX];
  logic [31:0] p_imm [PMAX], exp_sd [PMAX];
  logic [31:0] rf [32], rf_g [32], rf_init [32];

  int          s_op [4], s_idx [4];
  logic [4:0]  s_rd [4], s_rs1 [4], s_rs2 [4];
  logic [31:0] s_imm [4];
  logic [31:0] ex_a, ex_b, mem_val, mem_sd, wb_val;

  always #5 clk = ~clk;

  hazard_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fwd_en_i(fwd_en),
    .id_rs1_i(id_rs1), .id_rs2_i(id_rs2), .id_use_rs1_i(id_use1),
    .id_use_rs2_i(id_use2), .id_store_i(id_store),
    .ex_rd_i(ex_rd), .ex_wen_i(ex_wen), .ex_load_i(ex_load),
    .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
    .mem_store_i(mem_store), .mem_rs2_i(mem_rs2),
    .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
    .stall_o(stall), .ex_bubble_o(bubble), .fwd_a_o(fa), .fwd_b_o(fb),
    .mem_sd_fwd_o(sdf)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", wd_cnt);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit wr_op(int op);
    return (op == OP_LW) || (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic [31:0] memfn(logic [31:0] a);
    return (a * 32'h9E3779B1) + 32'h0000_1234;
  endfunction

  task automatic zero_inputs();
    {id_rs1, id_rs2, ex_rd, ex_rs1, ex_rs2, mem_rd, mem_rs2, wb_rd} = '0;
    {id_use1, id_use2, id_store, ex_wen, ex_load, mem_wen, mem_load, mem_store, wb_wen} = '0;
  endtask

  task automatic clear_stages();
    for (int s = 0; s < 4; s++) begin
      s_op[s] = OP_NOP; s_idx[s] = -1; s_rd[s] = '0; s_rs1[s] = '0; s_rs2[s] = '0; s_imm[s] = '0;
    end
    ex_a = '0; ex_b = '0; mem_val = '0; mem_sd = '0; wb_val = '0;
  endtask

  task automatic drive_model();
    id_rs1 = s_rs1[0]; id_rs2 = s_rs2[0];
    id_use1 = (s_op[0] != OP_NOP);
    id_use2 = (s_op[0] == OP_SW) || (s_op[0] == OP_ADD) || (s_op[0] == OP_SUB);
    id_store = (s_op[0] == OP_SW);
    ex_rd = s_rd[1]; ex_wen = wr_op(s_op[1]); ex_load = (s_op[1] == OP_LW);
    ex_rs1 = s_rs1[1]; ex_rs2 = s_rs2[1];
    mem_rd = s_rd[2]; mem_wen = wr_op(s_op[2]); mem_load = (s_op[2] == OP_LW);
    mem_store = (s_op[2] == OP_SW); mem_rs2 = s_rs2[2];
    wb_rd = s_rd[3]; wb_wen = wr_op(s_op[3]);
  endtask

  task automatic mv(input int d, input int s);
    s_op[d] = s_op[s]; s_idx[d] = s_idx[s]; s_rd[d] = s_rd[s];
    s_rs1[d] = s_rs1[s]; s_rs2[d] = s_rs2[s]; s_imm[d] = s_imm[s];
  endtask

  task automatic put(input int i, input int op, input int rd, input int r1, input int r2, input int imm);
    p_op[i] = op; p_rd[i] = 5'(rd); p_rs1[i] = 5'(r1); p_rs2[i] = 5'(r2); p_imm[i] = 32'(imm);
  endtask

  // in-order reference
  task automatic golden(input int n);
    for (int r = 0; r < 32; r++) rf_g[r] = rf_init[r];
    for (int i = 0; i < n; i++) begin
      case (p_op[i])
        OP_LW:  rf_g[p_rd[i]] = memfn(rf_g[p_rs1[i]] + p_imm[i]);
        OP_SW:  exp_sd[i] = rf_g[p_rs2[i]];
        OP_ADD: rf_g[p_rd[i]] = rf_g[p_rs1[i]] + rf_g[p_rs2[i]];
        OP_SUB: rf_g[p_rd[i]] = rf_g[p_rs1[i]] - rf_g[p_rs2[i]];
        default: ;
      endcase
      rf_g[0] = '0;
    end
  endtask

  task automatic run_prog(input logic mode, input int n, input int exp_cyc, input string tag);
    int pc, cyc, done_cyc, mism;
    logic st, sd;
    logic [1:0] sa, sb;
    logic [31:0] ea, eb, ex_res, mem_out, sdv, id_a, id_b;
    golden(n);
    fwd_en = mode;
    clear_stages();
    for (int r = 0; r < 32; r++) rf[r] = rf_init[r];
    drive_model();
    pc = 0; cyc = 1; done_cyc = -1;
    while (done_cyc < 0 && cyc < 20000) begin
      @(negedge clk);
      st = stall; sa = fa; sb = fb; sd = sdf;
      chk(st == bubble, "R1 stall/bubble pair", bubble, st);
      if (wr_op(s_op[3]) && s_rd[3] != 0) rf[s_rd[3]] = wb_val;
      id_a = rf[s_rs1[0]]; id_b = rf[s_rs2[0]];
      ea = (sa == 2'd1) ? mem_val : (sa == 2'd2) ? wb_val : ex_a;
      eb = (sb == 2'd1) ? mem_val : (sb == 2'd2) ? wb_val : ex_b;
      case (s_op[1])
        OP_LW, OP_SW: ex_res = ea + s_imm[1];
        OP_ADD:       ex_res = ea + eb;
        OP_SUB:       ex_res = ea - eb;
        default:      ex_res = '0;
      endcase
      mem_out = (s_op[2] == OP_LW) ? memfn(mem_val) : mem_val;
      sdv = sd ? wb_val : mem_sd;
      if (s_op[2] == OP_SW)
        chk(sdv == exp_sd[s_idx[2]], {"R6 store data ", tag}, sdv, exp_sd[s_idx[2]]);
      @(posedge clk);
      mv(3, 2); wb_val = mem_out;
      mv(2, 1); mem_val = ex_res; mem_sd = eb;
      if (st) begin
        s_op[1] = OP_NOP; s_idx[1] = -1; s_rd[1] = '0; s_rs1[1] = '0; s_rs2[1] = '0; s_imm[1] = '0;
      end else begin
        mv(1, 0); ex_a = id_a; ex_b = id_b;
        if (pc < n) begin
          s_op[0] = p_op[pc]; s_idx[0] = pc; s_rd[0] = p_rd[pc];
          s_rs1[0] = p_rs1[pc]; s_rs2[0] = p_rs2[pc]; s_imm[0] = p_imm[pc];
        end else begin
          s_op[0] = OP_NOP; s_idx[0] = -1; s_rd[0] = '0; s_rs1[0] = '0; s_rs2[0] = '0; s_imm[0] = '0;
        end
        pc++;
      end
      cyc++;
      if (s_idx[3] == n - 1) done_cyc = cyc;
      drive_model();
    end
    @(negedge clk);
    if (wr_op(s_op[3]) && s_rd[3] != 0) rf[s_rd[3]] = wb_val;
    mism = 0;
    for (int r = 0; r < 32; r++) if (rf[r] !== rf_g[r]) mism++;
    chk(mism == 0, {"R4 R3 register state ", tag}, mism, 0);
    if (exp_cyc > 0) chk(done_cyc == exp_cyc, {"R9 R10 cycle count ", tag}, done_cyc, exp_cyc);
    @(posedge clk);
    clear_stages();
    drive_model();
  endtask

  task automatic load_groups(input int reps);
    for (int g = 0; g < reps; g++) begin
      put(4*g+0, OP_LW,  2, 4, 0, 0);
      put(4*g+1, OP_LW,  3, 2, 0, 0);
      put(4*g+2, OP_ADD, 4, 4, 3, 0);
      put(4*g+3, OP_SUB, 8, 8, 4, 0);
    end
  endtask

  task automatic start_direct(input logic mode);
    @(posedge clk); #1;
    zero_inputs();
    fwd_en = mode;
  endtask

  task automatic end_direct();
    #1 zero_inputs();
  endtask

  initial begin
    int rnd_seed;
    rnd_seed = $urandom(32'h00C0FFEE);
    for (int r = 0; r < 32; r++) rf_init[r] = (r == 0) ? 32'd0 : 32'(r) * 32'h101 + 32'd5;
    zero_inputs();
    fwd_en = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(stall == 1'b0 && bubble == 1'b0, "R1 reset idle stall", stall, 0);
    chk(fa == 2'd0 && fb == 2'd0 && sdf == 1'b0, "R3 reset idle selects", {fa, fb, sdf}, 0);

    // R2 load-use on operand B
    start_direct(1'b1);
    id_rs2 = 5'd3; id_use2 = 1'b1; id_rs1 = 5'd1; id_use1 = 1'b1;
    ex_rd = 5'd3; ex_wen = 1'b1; ex_load = 1'b1;
    #3 chk(stall && bubble, "R2 load-use stall", {stall, bubble}, 3);
    end_direct();

    // R6 store data after load: no stall
    start_direct(1'b1);
    id_rs1 = 5'd4; id_rs2 = 5'd3; id_use1 = 1'b1; id_use2 = 1'b1; id_store = 1'b1;
    ex_rd = 5'd3; ex_wen = 1'b1; ex_load = 1'b1;
    #3 chk(!stall, "R6 store data no stall", stall, 0);
    end_direct();

    // R6 base register after load: stall
    start_direct(1'b1);
    id_rs1 = 5'd3; id_rs2 = 5'd6; id_use1 = 1'b1; id_use2 = 1'b1; id_store = 1'b1;
    ex_rd = 5'd3; ex_wen = 1'b1; ex_load = 1'b1;
    #3 chk(stall, "R6 store base stalls", stall, 1);
    end_direct();

    // R6 late store-data bypass, R5 idle without bypassing
    start_direct(1'b1);
    mem_store = 1'b1; mem_rs2 = 5'd3; wb_rd = 5'd3; wb_wen = 1'b1;
    #3 chk(sdf, "R6 store data from writeback", sdf, 1);
    fwd_en = 1'b0;
    #1 chk(!sdf, "R5 no store bypass", sdf, 0);
    end_direct();

    // R4 youngest producer wins; memory-stage load is skipped
    start_direct(1'b1);
    ex_rs1 = 5'd7; ex_rs2 = 5'd7; mem_rd = 5'd7; mem_wen = 1'b1; wb_rd = 5'd7; wb_wen = 1'b1;
    #3 chk(fa == 2'd1 && fb == 2'd1, "R4 memory stage priority", {fa, fb}, 5);
    mem_load = 1'b1;
    #1 chk(fa == 2'd2, "R4 load in memory skipped", fa, 2);
    end_direct();

    // R7 register 0
    start_direct(1'b1);
    ex_rs1 = 5'd0; mem_rd = 5'd0; mem_wen = 1'b1; wb_rd = 5'd0; wb_wen = 1'b1;
    id_rs1 = 5'd0; id_use1 = 1'b1; ex_rd = 5'd0; ex_wen = 1'b1; ex_load = 1'b1;
    #3 chk(fa == 2'd0 && !stall, "R7 zero register ignored", {fa, stall}, 0);
    end_direct();

    // R8 non-writing producers
    start_direct(1'b0);
    id_rs1 = 5'd9; id_use1 = 1'b1; ex_rd = 5'd9; mem_rd = 5'd9;
    #3 chk(!stall, "R8 non-writer no stall", stall, 0);
    fwd_en = 1'b1; ex_rs1 = 5'd9; wb_rd = 5'd9;
    #1 chk(fa == 2'd0, "R8 non-writer no bypass", fa, 0);
    end_direct();

    // R5 no bypassing: memory stall, writeback release
    start_direct(1'b0);
    id_rs1 = 5'd5; id_use1 = 1'b1; mem_rd = 5'd5; mem_wen = 1'b1;
    #3 chk(stall, "R5 wait on memory stage", stall, 1);
    mem_wen = 1'b0; wb_rd = 5'd5; wb_wen = 1'b1; ex_rs1 = 5'd5;
    #1 chk(!stall && fa == 2'd0, "R5 release at writeback", {stall, fa}, 0);
    end_direct();

    // R3 ALU to next instruction: no stall
    start_direct(1'b1);
    id_rs1 = 5'd5; id_use1 = 1'b1; ex_rd = 5'd5; ex_wen = 1'b1;
    #3 chk(!stall, "R3 ALU no stall", stall, 0);
    end_direct();

    // R9 single group, R10 hundred groups
    load_groups(1);
    run_prog(1'b1, 4, 10, "R9 bypass");
    run_prog(1'b0, 4, 14, "R9 no bypass");
    load_groups(100);
    run_prog(1'b1, 400, 604, "R10 bypass");
    run_prog(1'b0, 400, 1004, "R10 no bypass");

    // random programs in both modes
    for (int t = 0; t < 6; t++) begin
      for (int i = 0; i < 80; i++) begin
        int r;
        int op;
        r = $urandom_range(0, 9);
        op = (r < 3) ? OP_LW : (r < 5) ? OP_SW : (r < 7) ? OP_ADD : (r < 9) ? OP_SUB : OP_NOP;
        put(i, op, $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 5),
            $urandom_range(0, 15));
      end
      run_prog(t[0], 80, -1, t[0] ? "random bypass" : "random no bypass");
    end

    summary();
    $finish;
  end
endmodule